// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block paces the instruction flow of a small processor core. It splits the incoming clock into four rotating phase strobes, so that four input clocks make one instruction cycle. While one instruction word executes from the instruction register, the next word is fetched from the address on the program counter. Non-branch instructions therefore retire at one per instruction cycle. The program memory, the decoder, the ALU and the register file are outside the block. Its only view of decoding is a branch-taken flag with a target address.

Two enumerated state machines do the work.

The phase machine steps PH_Q1 → PH_Q2 → PH_Q3 → PH_Q4 → PH_Q1 on every clock. The first three steps are the named transitions "advance". The PH_Q4 → PH_Q1 step is the "cycle wrap".

The execute-status machine changes state only on the cycle wrap. It has three states:
- EX_BOOT: the state after reset. The instruction register holds the no-op word and nothing executes.
- EX_RUN: a real instruction executes.
- EX_FLUSH: the discarded prefetched word runs as a forced no-op.

Its transitions are:
- "start": EX_BOOT → EX_RUN.
- "take": EX_RUN → EX_FLUSH, when the branch flag is high at PH_Q4.
- "resume": EX_FLUSH → EX_RUN.
- "stay": EX_RUN → EX_RUN.

Top module: `fetch_exec_sequencer`

## Requirements
- R1: While reset is asserted (active-low, asynchronous), the outputs are fixed: `phase_o` is 4'b0001, `pc_o` is 0, `ir_o` holds the no-op word 16'h0000, and `flush_o`, `dmem_rd_o` and `dmem_wr_o` are all 0.
- R2: Exactly one bit of `phase_o` is high on every clock. Bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4. The high bit rotates in the order Q1, Q2, Q3, Q4, Q1.
- R3: `clk_div_o` is high during Q1 and Q2 and low during Q3 and Q4.
- R4: `pc_o` changes only at the clock edge that ends Q4, so any new value is visible from Q1. When no branch is taken, it advances by 2.
- R5: At the edge that ends Q4, `ir_o` loads `fetch_word_i`, unless a branch is taken at that edge. `ir_o` holds its value through the rest of the cycle.
- R6: In an executing cycle (EX_RUN), `dmem_rd_o` is high only in Q2 and `dmem_wr_o` is high only in Q4.
- R7: If `branch_taken_i` is high in Q4 of an executing cycle, the edge that ends Q4 does three things: it loads `branch_target_i` into `pc_o`, it loads the no-op word into `ir_o`, and it raises `flush_o` for all four phases of the next instruction cycle.
- R8: In a flush cycle, `dmem_rd_o` and `dmem_wr_o` stay low and `branch_taken_i` is ignored. The program counter then advances by 2 from the target.
- R9: In the first instruction cycle after reset, no data-memory strobe is raised and `branch_taken_i` is ignored.
- R10: The 21-bit program counter wraps modulo 2^21 with no other effect. For example, 21'h1FFFFE advances to 0.
- R11: `branch_taken_i` and `branch_target_i` have no effect in Q1, Q2 or Q3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; four periods make one instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_word_i | input | 16 | Program memory word at address `pc_o` |
| branch_taken_i | input | 1 | Executing instruction redirects the program counter (sampled in Q4) |
| branch_target_i | input | 21 | Redirect address (sampled in Q4) |
| pc_o | output | 21 | Program counter, used as the fetch address |
| ir_o | output | 16 | Instruction register, the word executing this cycle |
| phase_o | output | 4 | One-hot phase strobes; bit 0 is Q1 |
| dmem_rd_o | output | 1 | Data-memory operand read strobe (Q2) |
| dmem_wr_o | output | 1 | Data-memory destination write strobe (Q4) |
| clk_div_o | output | 1 | Clock divided by four, high in Q1 and Q2 |
| flush_o | output | 1 | High for the whole instruction cycle that runs a discarded word |

## Verification
A wrong phase state shows at once on `phase_o` and `clk_div_o`, within one clock of the fault. A wrong execute status shows on the memory strobes within two clocks, at the next Q2. It shows on `flush_o` at once. A program counter or instruction register that is corrupted, or loaded at the wrong edge, shows on `pc_o` and `ir_o` in the same phase. A mistaken branch decision diverges from the bench's model at the next Q1, at the latest four clocks after the sampled Q4.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int NUM_PHASES = 4;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        EX_BOOT  = 2'd0,
        EX_RUN   = 2'd1,
        EX_FLUSH = 2'd2
    } exec_e;

endpackage

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
    import seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [NUM_PHASES-1:0] strobe_o,
    output logic                  clk_div_o
);

    phase_e state_q, state_d;

    // next-state logic: advance, or the cycle wrap from Q4
    always_comb begin
        unique case (state_q)
            PH_Q1:   state_d = PH_Q2;
            PH_Q2:   state_d = PH_Q3;
            PH_Q3:   state_d = PH_Q4;
            PH_Q4:   state_d = PH_Q1;
            default: state_d = PH_Q1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_Q1;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PH_Q1:   begin strobe_o = 4'b0001; clk_div_o = 1'b1; end
            PH_Q2:   begin strobe_o = 4'b0010; clk_div_o = 1'b1; end
            PH_Q3:   begin strobe_o = 4'b0100; clk_div_o = 1'b0; end
            PH_Q4:   begin strobe_o = 4'b1000; clk_div_o = 1'b0; end
            default: begin strobe_o = 4'b0001; clk_div_o = 1'b1; end
        endcase
    end

    assert_q4_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o[3] |=> strobe_o[0]);
    assert_q1_to_q2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o[0] |=> strobe_o[1]);
    assert_div_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o[1] |=> !clk_div_o);

endmodule

// File: rtl/seq_fetch_unit.sv
module seq_fetch_unit
    import seq_pkg::*;
#(
    parameter int PC_W     = 21,
    parameter int INSN_W   = 16,
    parameter int PC_STEP  = 2,
    parameter logic [INSN_W-1:0] NOP_WORD = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] strobe_i,
    input  logic [INSN_W-1:0]     fetch_word_i,
    input  logic                  branch_taken_i,
    input  logic [PC_W-1:0]       branch_target_i,
    output logic [PC_W-1:0]       pc_o,
    output logic [INSN_W-1:0]     ir_o,
    output logic                  dmem_rd_o,
    output logic                  dmem_wr_o,
    output logic                  flush_o
);

    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    exec_e             ex_q, ex_d;
    logic [PC_W-1:0]   pc_q;
    logic [INSN_W-1:0] ir_q;
    logic              at_q2, at_q4, running, take;

    assign at_q2   = strobe_i[1];
    assign at_q4   = strobe_i[3];
    assign running = (ex_q == EX_RUN);
    assign take    = at_q4 && running && branch_taken_i;

    // execute-status transitions, decided only at the cycle wrap
    always_comb begin
        ex_d = ex_q;
        if (at_q4) begin
            unique case (ex_q)
                EX_BOOT:  ex_d = EX_RUN;
                EX_RUN:   ex_d = branch_taken_i ? EX_FLUSH : EX_RUN;
                EX_FLUSH: ex_d = EX_RUN;
                default:  ex_d = EX_BOOT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_q <= EX_BOOT;
            pc_q <= '0;
            ir_q <= NOP_WORD;
        end else begin
            ex_q <= ex_d;
            if (at_q4) begin
                pc_q <= take ? branch_target_i : pc_q + STEP;
                ir_q <= take ? NOP_WORD : fetch_word_i;
            end
        end
    end

    always_comb begin
        pc_o      = pc_q;
        ir_o      = ir_q;
        flush_o   = (ex_q == EX_FLUSH);
        dmem_rd_o = running && at_q2;
        dmem_wr_o = running && at_q4;
    end

    assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !at_q4 |=> $stable(pc_o));
    assert_ir_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !at_q4 |=> $stable(ir_o));
    assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (at_q4 && !take) |=> (pc_o == $past(pc_o) + STEP));
    assert_take_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (flush_o && ir_o == NOP_WORD && pc_o == $past(branch_target_i)));
    assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (!dmem_rd_o && !dmem_wr_o));
    assert_flush_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o && at_q4) |=> !flush_o);

endmodule

// File: rtl/fetch_exec_sequencer.sv
module fetch_exec_sequencer
    import seq_pkg::*;
#(
    parameter int PC_W    = 21,
    parameter int INSN_W  = 16,
    parameter int PC_STEP = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [INSN_W-1:0]     fetch_word_i,
    input  logic                  branch_taken_i,
    input  logic [PC_W-1:0]       branch_target_i,
    output logic [PC_W-1:0]       pc_o,
    output logic [INSN_W-1:0]     ir_o,
    output logic [NUM_PHASES-1:0] phase_o,
    output logic                  dmem_rd_o,
    output logic                  dmem_wr_o,
    output logic                  clk_div_o,
    output logic                  flush_o
);

    logic [NUM_PHASES-1:0] strobe;

    seq_phase_fsm u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_o  (strobe),
        .clk_div_o (clk_div_o)
    );

    seq_fetch_unit #(
        .PC_W     (PC_W),
        .INSN_W   (INSN_W),
        .PC_STEP  (PC_STEP),
        .NOP_WORD ('0)
    ) u_fetch (
        .clk             (clk),
        .rst_n           (rst_n),
        .strobe_i        (strobe),
        .fetch_word_i    (fetch_word_i),
        .branch_taken_i  (branch_taken_i),
        .branch_target_i (branch_target_i),
        .pc_o            (pc_o),
        .ir_o            (ir_o),
        .dmem_rd_o       (dmem_rd_o),
        .dmem_wr_o       (dmem_wr_o),
        .flush_o         (flush_o)
    );

    assign phase_o = strobe;

    assert_strobe_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_rd_o |-> phase_o[1]) and (dmem_wr_o |-> phase_o[3]));

endmodule

// File: tb/fetch_exec_sequencer_bench.sv
module fetch_exec_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fetch_word_i = '0;
    logic        branch_taken_i = 1'b0;
    logic [20:0] branch_target_i = '0;
    logic [20:0] pc_o;
    logic [15:0] ir_o;
    logic [3:0]  phase_o;
    logic        dmem_rd_o, dmem_wr_o, clk_div_o, flush_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    int          m_ph;
    logic [20:0] m_pc;
    logic [15:0] m_ir;
    bit          m_run, m_flush;

    fetch_exec_sequencer u_fetch_exec_sequencer (.*);

    always #5 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle phase %0d)", tag, act, exp, m_ph);
        end
    endtask

    function automatic logic [3:0] exp_strobe(int ph);
        return 4'b0001 << ph;
    endfunction

    function automatic logic [20:0] exp_next_pc(logic [20:0] pc, bit tk, logic [20:0] tgt);
        return tk ? tgt : pc + 21'd2;
    endfunction

    task automatic model_reset();
        m_ph = 0; m_pc = '0; m_ir = '0; m_run = 0; m_flush = 0;
    endtask

    // compare all outputs with the model
    task automatic compare_all();
        check("R2 phase strobe", {28'd0, phase_o}, {28'd0, exp_strobe(m_ph)});
        check("R3 divided clock", {31'd0, clk_div_o}, {31'd0, (m_ph < 2)});
        check("R4/R7/R10 program counter", {11'd0, pc_o}, {11'd0, m_pc});
        check("R5/R7 instruction register", {16'd0, ir_o}, {16'd0, m_ir});
        check("R6/R8/R9 read strobe", {31'd0, dmem_rd_o}, {31'd0, (m_run && m_ph == 1)});
        check("R6/R8/R9 write strobe", {31'd0, dmem_wr_o}, {31'd0, (m_run && m_ph == 3)});
        check("R7/R8 flush", {31'd0, flush_o}, {31'd0, m_flush});
    endtask

    // advance the model using the inputs that the next edge samples
    task automatic model_step();
        bit tk;
        if (m_ph == 3) begin
            tk = branch_taken_i && m_run;
            m_pc = exp_next_pc(m_pc, tk, branch_target_i);
            m_ir = tk ? 16'h0000 : fetch_word_i;
            m_flush = tk;
            m_run = !tk;
        end
        m_ph = (m_ph + 1) % 4;
    endtask

    task automatic run_cycle(bit br, logic [20:0] tgt);
        @(negedge clk);
        compare_all();
        fetch_word_i    = 16'($urandom);
        branch_taken_i  = br;
        branch_target_i = tgt;
        model_step();
    endtask

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        // R1: reset state, checked while reset is held
        repeat (3) @(negedge clk);
        check("R1 phase", {28'd0, phase_o}, 32'h1);
        check("R1 pc", {11'd0, pc_o}, 32'h0);
        check("R1 ir", {16'd0, ir_o}, 32'h0);
        check("R1 flush", {31'd0, flush_o}, 32'h0);
        check("R1 rd", {31'd0, dmem_rd_o}, 32'h0);
        check("R1 wr", {31'd0, dmem_wr_o}, 32'h0);
        branch_taken_i  = 1'b1;   // R9: branch held during the first cycle
        branch_target_i = 21'h00_0100;
        rst_n = 1'b1;
        model_step();
        for (int i = 0; i < 7; i++) run_cycle(1'b1, 21'h00_0100);
        // R7 R8 R10: branch to the top of the space, flag held through flush
        for (int i = 0; i < 12; i++) run_cycle(1'b1, 21'h1F_FFFE);
        for (int i = 0; i < 12; i++) run_cycle(1'b0, 21'h0);
        // R11: flag toggling outside Q4, plus random branching
        for (int i = 0; i < 3000; i++) begin
            bit br;
            br = ($urandom % 100) < 30;
            run_cycle(br, {$urandom} & 21'h1F_FFFE);
        end
        // R1: asynchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async pc", {11'd0, pc_o}, 32'h0);
        check("R1 async phase", {28'd0, phase_o}, 32'h1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule